// File: doc/BRIEF.md
# Debug Stall Control and Status Registers

This unit is the register front end of an on-chip debug block for an 8-bit processor. It holds three byte-wide registers on a plain memory-mapped bus: a first control/status byte, a second control/status byte and a function-enable mask. A bus write happens on the clock edge while `bus_we` is high. The read data is combinational from the address. Addresses other than the three registers read as zero.

The unit owns the processor stall line. While the debug link is active, the stall bit can be written from the bus. Trap, reset-stall, breakpoint, enabled single-step and enabled software-break events also set it. Each of these events, except trap, also raises its own sticky cause flag. All the sticky flags drop together on the cycle in which the stall is released. While the core is stalled, every function-enable bit that is 0 drives its freeze line, which holds the matching peripheral function still. A separate decode-flush request is raised by software and dropped when the processor reports that the flush is done.

Top module: `dbg_stall_regs`

## Requirements
- R1: After reset, the register at BASE_ADDR (CSR1) reads 0x10, the one at BASE_ADDR+1 (CSR2) reads 0x00 and the one at BASE_ADDR+2 (function enable) reads 0xFF. Every other address reads 0x00.
- R2: The step enable in CSR1 bit 6, the software-break enable in CSR2 bit 5 and all eight function-enable bits can be written and read back, and they drive `step_en` and `swbrk_en`. CSR1 bits 7 and 0 and CSR2 bits 7:6 and 2:1 always read 0.
- R3: Bus writes leave the status bits unchanged. These are CSR1 bit 5 (step flag), bit 4 (reset flag), bit 3 (read/write indicator), bit 2 (breakpoint 2 flag) and bit 1 (breakpoint 1 flag), and CSR2 bit 4 (software-break flag).
- R4: The stall bit (CSR2 bit 3, `cpu_stall`) takes a written value only while `link_active` is 1. It is 0 in the cycle after any cycle in which `link_active` is 0, and every event input is ignored in such a cycle.
- R5: A trap sets the stall and raises no flag. A reset-stall event sets the stall and the reset flag.
- R6: A breakpoint 1 or breakpoint 2 hit sets the stall and its own flag. Every breakpoint hit loads `ev_bp_is_read` into the read/write indicator (1 = read, 0 = write).
- R7: A software-break fetch with the enable at 1 sets the stall and the software-break flag. With the enable at 0, it changes nothing.
- R8: A step-complete pulse with step enable at 1 sets the stall and the step flag. With step enable at 0, it changes nothing.
- R9: When the stall goes from 1 to 0, the step, reset, breakpoint 1, breakpoint 2 and software-break flags all clear. The read/write indicator keeps its value.
- R10: A stall-setting event in the same cycle as a write of 0 to the stall bit wins. The stall stays 1 and no flag clears.
- R11: Writing 1 to CSR2 bit 0 sets `flush_req`, and writing 0 there has no effect. `flush_done` clears `flush_req`, unless a write of 1 happens in the same cycle.
- R12: Freeze line i is 1 exactly when the core is stalled and function-enable bit i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_rdata | output | 8 | Combinational read data |
| link_active | input | 1 | Debug link mode active |
| ev_step_done | input | 1 | Single step completed |
| ev_bp1 | input | 1 | Breakpoint 1 hit |
| ev_bp2 | input | 1 | Breakpoint 2 hit |
| ev_bp_is_read | input | 1 | Breakpoint access was a read |
| ev_swbrk_fetch | input | 1 | Software-break instruction fetched |
| ev_trap | input | 1 | Debug trap |
| ev_reset_stall | input | 1 | Stall requested right after reset |
| flush_done | input | 1 | Decode flush completed |
| cpu_stall | output | 1 | Processor stall |
| flush_req | output | 1 | Decode flush request |
| step_en | output | 1 | Step mode enabled |
| swbrk_en | output | 1 | Software breakpoints enabled |
| freeze | output | NFUNC | Per-function freeze lines |

## Verification
The properties assume that event inputs are single-cycle levels sampled at the clock edge. They also assume that `link_active` can change in any cycle, that any mix of events can coincide with a bus write, and that `flush_done` can arrive with no request pending. The random stimulus keeps to these assumptions. It drives `link_active` low only now and then, so that stalls last long enough to be seen. It pulses each event independently and at a low rate, so events coincide with each other and with writes to every register. It draws addresses from one below the register window to one above it, so that unmapped reads are covered too.

// File: rtl/dbg_stall_pkg.sv
// Shared constants and types for the debug stall register unit.
// Assumes an 8-bit data bus. The bit positions are what software decodes.
package dbg_stall_pkg;
    localparam int DATA_W     = 8;
    // First control/status byte
    localparam int C1_STEP_EN = 6;
    localparam int C1_STEPF   = 5;
    localparam int C1_RSTF    = 4;
    localparam int C1_BRW     = 3;
    localparam int C1_BP2F    = 2;
    localparam int C1_BP1F    = 1;
    // Second control/status byte
    localparam int C2_SW_EN   = 5;
    localparam int C2_SWF     = 4;
    localparam int C2_STALL   = 3;
    localparam int C2_FLUSH   = 0;

    // Sticky stall-cause flags
    typedef struct packed {
        logic step;
        logic rst;
        logic bp2;
        logic bp1;
        logic sw;
    } dbg_flags_t;
endpackage

// File: rtl/dbg_stall_core.sv
// Stall bit, sticky cause flags and breakpoint read/write indicator.
// Assumes events are one-cycle levels. All events are ignored while the
// debug link is inactive. A set event beats a stall-clear write.
module dbg_stall_core
    import dbg_stall_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_active,
    input  logic       step_en,
    input  logic       swbrk_en,
    input  logic       ev_step_done,
    input  logic       ev_bp1,
    input  logic       ev_bp2,
    input  logic       ev_bp_is_read,
    input  logic       ev_swbrk_fetch,
    input  logic       ev_trap,
    input  logic       ev_reset_stall,
    input  logic       stall_wr,
    input  logic       stall_wr_val,
    output logic       stall_q,
    output dbg_flags_t flags_q,
    output logic       brw_q
);
    dbg_flags_t hit;
    logic       any_set;
    logic       stall_d;
    logic       release_s;

    // Qualify each event by link mode and its enable
    always_comb begin
        hit.step = link_active & ev_step_done & step_en;
        hit.rst  = link_active & ev_reset_stall;
        hit.bp2  = link_active & ev_bp2;
        hit.bp1  = link_active & ev_bp1;
        hit.sw   = link_active & ev_swbrk_fetch & swbrk_en;
        any_set  = (|hit) | (link_active & ev_trap);
    end

    // Next stall value: link off forces 0, events beat writes
    always_comb begin
        if (!link_active)  stall_d = 1'b0;
        else if (any_set)  stall_d = 1'b1;
        else if (stall_wr) stall_d = stall_wr_val;
        else               stall_d = stall_q;
        release_s = stall_q & ~stall_d;
    end

    // Stall, flag and read/write indicator registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            flags_q <= '{step: 1'b0, rst: 1'b1, bp2: 1'b0, bp1: 1'b0, sw: 1'b0};
            brw_q   <= 1'b0;
        end else begin
            stall_q <= stall_d;
            flags_q <= hit | (flags_q & {$bits(dbg_flags_t){~release_s}});
            if (hit.bp1 | hit.bp2) brw_q <= ev_bp_is_read;
        end
    end
endmodule

// File: rtl/dbg_flush_ctrl.sv
// Decode-flush request: set by software, cleared by the flush-done input.
// Assumes a set in the same cycle as done wins, so no request is lost.
module dbg_flush_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic done,
    output logic flush_q
);
    // Request register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)       flush_q <= 1'b0;
        else if (set_req) flush_q <= 1'b1;
        else if (done)    flush_q <= 1'b0;
    end
endmodule

// File: rtl/dbg_freeze_gate.sv
// Per-function freeze lines. A function freezes while the core is stalled
// and its enable bit is 0. Purely combinational.
module dbg_freeze_gate #(
    parameter int NFUNC = 8
) (
    input  logic             stall,
    input  logic [NFUNC-1:0] fn_en,
    output logic [NFUNC-1:0] freeze
);
    for (genvar i = 0; i < NFUNC; i++) begin : g_fn
        // One gate per peripheral function
        assign freeze[i] = stall & ~fn_en[i];
    end
endmodule

// File: rtl/dbg_stall_regs.sv
// Top of the debug stall register unit: address decode, writable
// configuration bits, read mux and the sub-blocks. Assumes single-cycle
// writes and combinational reads. NFUNC must not exceed the data width.
module dbg_stall_regs
    import dbg_stall_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h7F98,
    parameter int              NFUNC     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              link_active,
    input  logic              ev_step_done,
    input  logic              ev_bp1,
    input  logic              ev_bp2,
    input  logic              ev_bp_is_read,
    input  logic              ev_swbrk_fetch,
    input  logic              ev_trap,
    input  logic              ev_reset_stall,
    input  logic              flush_done,
    output logic              cpu_stall,
    output logic              flush_req,
    output logic              step_en,
    output logic              swbrk_en,
    output logic [NFUNC-1:0]  freeze
);
    localparam logic [ADDR_W-1:0] A_CSR1 = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_CSR2 = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FEN  = BASE_ADDR + ADDR_W'(2);

    logic             wr_csr1, wr_csr2, wr_fen;
    logic             step_en_q, swbrk_en_q;
    logic [NFUNC-1:0] fn_en_q;
    logic             stall_q, brw_q, flush_q;
    dbg_flags_t       flags_q;
    logic [7:0]       csr1_v, csr2_v, fen_v;

    // Write strobes per register
    always_comb begin
        wr_csr1 = bus_we && (bus_addr == A_CSR1);
        wr_csr2 = bus_we && (bus_addr == A_CSR2);
        wr_fen  = bus_we && (bus_addr == A_FEN);
    end

    // Software-owned configuration bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_en_q  <= 1'b0;
            swbrk_en_q <= 1'b0;
            fn_en_q    <= '1;
        end else begin
            if (wr_csr1) step_en_q  <= bus_wdata[C1_STEP_EN];
            if (wr_csr2) swbrk_en_q <= bus_wdata[C2_SW_EN];
            if (wr_fen)  fn_en_q    <= bus_wdata[NFUNC-1:0];
        end
    end

    dbg_stall_core u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .link_active    (link_active),
        .step_en        (step_en_q),
        .swbrk_en       (swbrk_en_q),
        .ev_step_done   (ev_step_done),
        .ev_bp1         (ev_bp1),
        .ev_bp2         (ev_bp2),
        .ev_bp_is_read  (ev_bp_is_read),
        .ev_swbrk_fetch (ev_swbrk_fetch),
        .ev_trap        (ev_trap),
        .ev_reset_stall (ev_reset_stall),
        .stall_wr       (wr_csr2),
        .stall_wr_val   (bus_wdata[C2_STALL]),
        .stall_q        (stall_q),
        .flags_q        (flags_q),
        .brw_q          (brw_q)
    );

    dbg_flush_ctrl u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_csr2 & bus_wdata[C2_FLUSH]),
        .done    (flush_done),
        .flush_q (flush_q)
    );

    dbg_freeze_gate #(.NFUNC(NFUNC)) u_freeze (
        .stall  (stall_q),
        .fn_en  (fn_en_q),
        .freeze (freeze)
    );

    // Assemble register images
    always_comb begin
        csr1_v = '0;
        csr1_v[C1_STEP_EN] = step_en_q;
        csr1_v[C1_STEPF]   = flags_q.step;
        csr1_v[C1_RSTF]    = flags_q.rst;
        csr1_v[C1_BRW]     = brw_q;
        csr1_v[C1_BP2F]    = flags_q.bp2;
        csr1_v[C1_BP1F]    = flags_q.bp1;
        csr2_v = '0;
        csr2_v[C2_SW_EN]   = swbrk_en_q;
        csr2_v[C2_SWF]     = flags_q.sw;
        csr2_v[C2_STALL]   = stall_q;
        csr2_v[C2_FLUSH]   = flush_q;
        fen_v = '0;
        fen_v[NFUNC-1:0]   = fn_en_q;
    end

    // Read mux; unmapped addresses read zero
    always_comb begin
        if (bus_addr == A_CSR1)      bus_rdata = csr1_v;
        else if (bus_addr == A_CSR2) bus_rdata = csr2_v;
        else if (bus_addr == A_FEN)  bus_rdata = fen_v;
        else                         bus_rdata = '0;
    end

    assign cpu_stall = stall_q;
    assign flush_req = flush_q;
    assign step_en   = step_en_q;
    assign swbrk_en  = swbrk_en_q;
endmodule

// File: rtl/dbg_stall_regs_chk.sv
// Assertion checker for dbg_stall_regs, attached by bind below.
// Assumes the same synchronous active-low reset as the design.
module dbg_stall_regs_chk
    import dbg_stall_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h7F98,
    parameter int                NFUNC     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_active,
    input logic              ev_trap,
    input logic              ev_swbrk_fetch,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              flush_done,
    input logic              cpu_stall,
    input logic              flush_req,
    input logic              swbrk_en,
    input logic [NFUNC-1:0]  freeze,
    input dbg_flags_t        flags_q
);
    logic wr2;
    assign wr2 = bus_we && (bus_addr == BASE_ADDR + ADDR_W'(1));

    AST_STALL_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !link_active |=> !cpu_stall); // R4
    AST_TRAP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        link_active && ev_trap |=> cpu_stall); // R5
    AST_SWBRK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !swbrk_en && !flags_q.sw |=> !flags_q.sw); // R7
    AST_FLAGS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> flags_q == '0); // R9
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        link_active && ev_swbrk_fetch && swbrk_en && wr2 && !bus_wdata[C2_STALL]
        |=> cpu_stall && flags_q.sw); // R10
    AST_FLUSH_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && flush_done && !(wr2 && bus_wdata[C2_FLUSH]) |=> !flush_req); // R11
    AST_NO_FREEZE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> freeze == '0); // R12
endmodule

bind dbg_stall_regs dbg_stall_regs_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NFUNC(NFUNC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .link_active    (link_active),
    .ev_trap        (ev_trap),
    .ev_swbrk_fetch (ev_swbrk_fetch),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .flush_done     (flush_done),
    .cpu_stall      (cpu_stall),
    .flush_req      (flush_req),
    .swbrk_en       (swbrk_en),
    .freeze         (freeze),
    .flags_q        (flags_q)
);

// File: tb/dbg_stall_regs_bench.sv
module dbg_stall_regs_bench;
    localparam logic [15:0] A1 = 16'h7F98;
    localparam logic [15:0] A2 = 16'h7F99;
    localparam logic [15:0] AF = 16'h7F9A;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        link_active = 1'b1;
    logic        ev_step_done = 0, ev_bp1 = 0, ev_bp2 = 0, ev_bp_is_read = 0;
    logic        ev_swbrk_fetch = 0, ev_trap = 0, ev_reset_stall = 0, flush_done = 0;
    logic        cpu_stall, flush_req, step_en, swbrk_en;
    logic [7:0]  freeze;

    dbg_stall_regs u_dbg_stall_regs (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic m_step_en, m_sw_en, m_stall, m_flush, m_brw;
    logic m_stepf, m_rstf, m_bp2f, m_bp1f, m_swf;
    logic [7:0] m_fn;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(logic [15:0] a);
        if (a == A1) return {1'b0, m_step_en, m_stepf, m_rstf, m_brw, m_bp2f, m_bp1f, 1'b0};
        if (a == A2) return {2'b00, m_sw_en, m_swf, m_stall, 2'b00, m_flush};
        if (a == AF) return m_fn;
        return 8'h00;
    endfunction

    task automatic m_reset();
        m_step_en = 0; m_sw_en = 0; m_stall = 0; m_flush = 0; m_brw = 0;
        m_stepf = 0; m_rstf = 1; m_bp2f = 0; m_bp1f = 0; m_swf = 0; m_fn = 8'hFF;
    endtask

    // Advance the reference by one clock using the held inputs
    task automatic m_step();
        logic l, hs, hr, h2, h1, hw, anys, nst, rel, w1, w2, wf;
        l  = link_active;
        hs = l & ev_step_done & m_step_en;
        hr = l & ev_reset_stall;
        h2 = l & ev_bp2;
        h1 = l & ev_bp1;
        hw = l & ev_swbrk_fetch & m_sw_en;
        anys = hs | hr | h2 | h1 | hw | (l & ev_trap);
        w1 = bus_we && bus_addr == A1;
        w2 = bus_we && bus_addr == A2;
        wf = bus_we && bus_addr == AF;
        nst = !l ? 1'b0 : anys ? 1'b1 : w2 ? bus_wdata[3] : m_stall;
        rel = m_stall & ~nst;
        m_stepf = hs | (m_stepf & ~rel);
        m_rstf  = hr | (m_rstf & ~rel);
        m_bp2f  = h2 | (m_bp2f & ~rel);
        m_bp1f  = h1 | (m_bp1f & ~rel);
        m_swf   = hw | (m_swf & ~rel);
        if (h1 | h2) m_brw = ev_bp_is_read;
        m_stall = nst;
        if (w2 && bus_wdata[0]) m_flush = 1'b1;
        else if (flush_done)    m_flush = 1'b0;
        if (w1) m_step_en = bus_wdata[6];
        if (w2) m_sw_en   = bus_wdata[5];
        if (wf) m_fn      = bus_wdata;
    endtask

    task automatic check_outputs();
        chk("R3 rdata",     bus_rdata, m_read(bus_addr));
        chk("R4 cpu_stall", cpu_stall, m_stall);
        chk("R11 flush",    flush_req, m_flush);
        chk("R2 step_en",   step_en,   m_step_en);
        chk("R2 swbrk_en",  swbrk_en,  m_sw_en);
        chk("R12 freeze",   freeze,    {8{m_stall}} & ~m_fn);
    endtask

    // Called just after a falling edge with inputs set
    task automatic run_cycle();
        #2;
        check_outputs();
        @(posedge clk);
        m_step();
        @(negedge clk);
        bus_we = 0; ev_step_done = 0; ev_bp1 = 0; ev_bp2 = 0; ev_bp_is_read = 0;
        ev_swbrk_fetch = 0; ev_trap = 0; ev_reset_stall = 0; flush_done = 0;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        run_cycle();
    endtask

    task automatic idle();
        run_cycle();
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [7:0] exp);
        bus_addr = a; bus_we = 0;
        #2;
        chk(req, bus_rdata, exp);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        rd_chk("R1 csr1 reset", A1, 8'h10);
        rd_chk("R1 csr2 reset", A2, 8'h00);
        rd_chk("R1 fen reset",  AF, 8'hFF);
        rd_chk("R1 unmapped",   16'h7F9B, 8'h00);
        chk("R1 stall reset", cpu_stall, 1'b0);
        rst_n = 1'b1;
        idle();

        // R2/R3: write all ones to CSR1, status bits hold
        wr(A1, 8'hFF);
        rd_chk("R3 csr1 ro bits", A1, 8'h50);
        wr(A2, 8'hE6);
        rd_chk("R2 csr2 reserved", A2, 8'h20);

        // R4: stall write ignored with link off, taken with link on
        link_active = 0;
        wr(A2, 8'h28);
        chk("R4 write ignored no link", cpu_stall, 1'b0);
        link_active = 1;
        wr(A2, 8'h28);
        chk("R4 write taken", cpu_stall, 1'b1);
        wr(A2, 8'h20);
        rd_chk("R9 reset flag cleared", A1, 8'h40);

        // R8 step
        ev_step_done = 1; run_cycle();
        rd_chk("R8 step sets flag", A1, 8'h60);
        chk("R8 step stalls", cpu_stall, 1'b1);
        wr(A2, 8'h20);
        wr(A1, 8'h00);
        ev_step_done = 1; run_cycle();
        rd_chk("R8 step disabled", A1, 8'h00);
        chk("R8 step disabled stall", cpu_stall, 1'b0);

        // R7 software break
        ev_swbrk_fetch = 1; run_cycle();
        rd_chk("R7 swbrk enabled", A2, 8'h38);
        wr(A2, 8'h20);
        wr(A2, 8'h00);
        ev_swbrk_fetch = 1; run_cycle();
        rd_chk("R7 swbrk disabled", A2, 8'h00);

        // R6 breakpoints and read/write indicator
        ev_bp1 = 1; ev_bp_is_read = 1; run_cycle();
        rd_chk("R6 bp1 read", A1, 8'h0A);
        ev_bp2 = 1; ev_bp_is_read = 0; run_cycle();
        rd_chk("R6 bp2 write", A1, 8'h06);
        wr(A2, 8'h00);
        rd_chk("R9 flags clear", A1, 8'h00);
        ev_bp2 = 1; ev_bp_is_read = 1; run_cycle();
        rd_chk("R6 bp2 read", A1, 8'h0C);
        wr(A2, 8'h00);
        rd_chk("R9 brw kept", A1, 8'h08);

        // R5 trap and reset-stall
        ev_trap = 1; run_cycle();
        chk("R5 trap stalls", cpu_stall, 1'b1);
        rd_chk("R5 trap no flag", A1, 8'h08);
        ev_reset_stall = 1; run_cycle();
        rd_chk("R5 reset flag", A1, 8'h18);

        // R10 event beats clear write
        bus_addr = A2; bus_wdata = 8'h00; bus_we = 1; ev_trap = 1; run_cycle();
        chk("R10 stall held", cpu_stall, 1'b1);
        rd_chk("R10 flags kept", A1, 8'h18);

        // R12 freeze mask
        wr(AF, 8'h5A);
        chk("R12 freeze stalled", freeze, 8'hA5);
        wr(A2, 8'h00);
        chk("R12 freeze running", freeze, 8'h00);

        // R4 link drop releases stall and clears flags
        ev_reset_stall = 1; run_cycle();
        link_active = 0; idle();
        chk("R4 link drop", cpu_stall, 1'b0);
        rd_chk("R9 link drop clears", A1, 8'h08);
        link_active = 1;

        // R11 flush
        wr(A2, 8'h01);
        chk("R11 flush set", flush_req, 1'b1);
        wr(A2, 8'h00);
        chk("R11 write 0 no effect", flush_req, 1'b1);
        flush_done = 1; idle();
        chk("R11 done clears", flush_req, 1'b0);
        bus_addr = A2; bus_wdata = 8'h01; bus_we = 1; flush_done = 1; run_cycle();
        chk("R11 set beats done", flush_req, 1'b1);

        // Random phase
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 4000; n++) begin
            bus_addr       = A1 - 16'd1 + 16'($urandom_range(0, 4));
            bus_wdata      = 8'($urandom);
            bus_we         = ($urandom_range(0, 3) == 0);
            link_active    = ($urandom_range(0, 15) != 0);
            ev_step_done   = ($urandom_range(0, 9) == 0);
            ev_bp1         = ($urandom_range(0, 9) == 0);
            ev_bp2         = ($urandom_range(0, 9) == 0);
            ev_bp_is_read  = 1'($urandom);
            ev_swbrk_fetch = ($urandom_range(0, 9) == 0);
            ev_trap        = ($urandom_range(0, 19) == 0);
            ev_reset_stall = ($urandom_range(0, 19) == 0);
            flush_done     = ($urandom_range(0, 5) == 0);
            run_cycle();
        end
        #2;
        check_outputs();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule